// File: doc/BRIEF.md
# DAC Sequencer DMA Control Register Bank

This block is the register bank that sits between a host register port and the DMA and status logic of a DAC output sequencer. The host writes a buffer base address and a byte length. A write to the length register is the request to start a DMA transfer. If the DMA engine reports idle at that moment, the block captures the base address and length together and issues a one-cycle start pulse. If the engine is busy, the request is dropped.

The bank also keeps two read-only counters. The first counts completed conversions. What clears it depends on the mode: a start-conversion command clears it in normal mode, and a frame trigger clears it in frame mode unless a frame error is flagged at that trigger. The second gives the sample FIFO fill level in bytes. It is derived from push and pop events, and each sample counts as two bytes. Reads are combinational from the selected register.

Top module: `dacseq_dma_regs`

## Requirements
- R1: After reset, all four registers read 0, `dma_start` is 0, and `dma_addr` and `dma_len` are 0.
- R2: The base address register at byte offset 0x8 is 32-bit read/write and reads back the last value written.
- R3: The length register at offset 0xC stores `wdata[27:0]` on every write. Reads return that value with bits 31:28 at 0.
- R4: A length write while `dma_idle`=1 drives `dma_start` high for exactly the cycle after the write edge. At that same edge, `dma_addr` takes the base register value and `dma_len` takes `wdata[27:0]`.
- R5: A length write while `dma_idle`=0 produces no `dma_start` pulse and leaves `dma_addr` and `dma_len` unchanged.
- R6: `dma_addr` and `dma_len` hold their values until the next accepted start, including across later base register writes.
- R7: The conversion count at offset 0x0 increments by 1 on each clock with `conv_done`=1. It reads in bits 27:0 with bits 31:28 at 0.
- R8: With `frame_mode`=0, `start_conv` clears the conversion count and `frame_trig` has no effect on it.
- R9: With `frame_mode`=1, `frame_trig` with `frame_err`=0 clears the count. `frame_trig` with `frame_err`=1 does not clear it, and neither does `start_conv`.
- R10: When a clear and `conv_done` occur in the same cycle, the count becomes 0.
- R11: The FIFO level at offset 0x4 rises by 2 per `fifo_push` and falls by 2 per `fifo_pop`. A push and a pop in the same cycle leave it unchanged.
- R12: A pop alone while the level is 0 leaves the level at 0.
- R13: Writes to offsets 0x0 and 0x4 have no effect on the values read there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| dma_idle | input | 1 | DMA engine idle status |
| conv_done | input | 1 | One conversion completed |
| start_conv | input | 1 | Start-conversion command |
| frame_mode | input | 1 | 1 selects frame mode, 0 selects normal mode |
| frame_trig | input | 1 | Frame trigger event |
| frame_err | input | 1 | Frame error flagged at this trigger |
| fifo_push | input | 1 | Sample written into the FIFO |
| fifo_pop | input | 1 | Sample taken from the FIFO |
| dma_start | output | 1 | One-cycle DMA start pulse |
| dma_addr | output | 32 | Captured buffer base address |
| dma_len | output | 28 | Captured buffer byte length |

## Verification
The hardest cases to reach are the coincident events. These are a clear arriving in the same cycle as `conv_done`, and a frame trigger that carries a frame error. Each needs several inputs raised on one exact edge, after the count has first been moved away from zero. The stimulus builds a known count, then drives the coincident inputs together for a single cycle from one task, in both modes. The busy-rejection case is also hard to see from the ports. It is reached by starting a transfer first, then writing a new length with idle low and confirming that the captured length still shows the earlier value.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;
  localparam int unsigned REG_W = 32;
  localparam logic [3:0] OFS_CONV = 4'h0;
  localparam logic [3:0] OFS_FILL = 4'h4;
  localparam logic [3:0] OFS_BASE = 4'h8;
  localparam logic [3:0] OFS_LEN  = 4'hC;

  // Clear rule of the conversion counter, selected by mode.
  function automatic logic conv_clear_cond(logic frame_mode, logic start_conv,
                                           logic frame_trig, logic frame_err);
    return frame_mode ? (frame_trig & ~frame_err) : start_conv;
  endfunction

  // Next fill level in bytes; floor at zero.
  function automatic logic [REG_W-1:0] fill_step(logic [REG_W-1:0] cur, logic push,
                                                 logic pop, logic [REG_W-1:0] step);
    logic [REG_W-1:0] r;
    r = cur;
    if (push && !pop) r = cur + step;
    else if (pop && !push) r = (cur >= step) ? cur - step : '0;
    return r;
  endfunction
endpackage

// File: rtl/dacseq_conv_cnt.sv
module dacseq_conv_cnt #(
  parameter int unsigned CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic             start_conv,
  input  logic             frame_mode,
  input  logic             frame_trig,
  input  logic             frame_err,
  output logic [CNT_W-1:0] cnt,
  output logic             clr_evt
);
  import dacseq_pkg::*;

  assign clr_evt = conv_clear_cond(frame_mode, start_conv, frame_trig, frame_err);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (clr_evt)   cnt <= '0;
    else if (conv_done) cnt <= cnt + 1'b1;
  end

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> cnt == '0);
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && conv_done) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  assert_frame_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_mode && !(frame_trig && !frame_err) && !conv_done) |=> $stable(cnt));
  assert_normal_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_mode && !start_conv && !conv_done) |=> $stable(cnt));
endmodule

// File: rtl/dacseq_fill_level.sv
module dacseq_fill_level #(
  parameter int unsigned LVL_W            = 32,
  parameter int unsigned BYTES_PER_SAMPLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] level
);
  import dacseq_pkg::*;
  localparam logic [REG_W-1:0] STEP = REG_W'(BYTES_PER_SAMPLE);

  logic [REG_W-1:0] level_nxt;
  assign level_nxt = fill_step(REG_W'(level), push, pop, STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) level <= '0;
    else        level <= level_nxt[LVL_W-1:0];
  end

  assert_fill_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(level));
  assert_fill_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> level == LVL_W'($past(level) + BYTES_PER_SAMPLE));
  assert_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && level == '0) |=> level == '0);
endmodule

// File: rtl/dacseq_dma_start.sv
module dacseq_dma_start #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_wr,
  input  logic              idle,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [LEN_W-1:0]  len_in,
  output logic              start,
  output logic [ADDR_W-1:0] addr_lat,
  output logic [LEN_W-1:0]  len_lat
);
  logic accept;
  assign accept = len_wr & idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start    <= 1'b0;
      addr_lat <= '0;
      len_lat  <= '0;
    end else begin
      start <= accept;
      if (accept) begin
        addr_lat <= base_q;
        len_lat  <= len_in;
      end
    end
  end

  assert_busy_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (len_wr && !idle) |=> !start);
  assert_latch_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(addr_lat) && $stable(len_lat)));
  assert_start_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (start && addr_lat == $past(base_q) && len_lat == $past(len_in)));
endmodule

// File: rtl/dacseq_dma_regs.sv
module dacseq_dma_regs #(
  parameter int unsigned ADDR_W           = 4,
  parameter int unsigned CNT_W            = 28,
  parameter int unsigned LEN_W            = 28,
  parameter int unsigned LVL_W            = 32,
  parameter int unsigned BYTES_PER_SAMPLE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              dma_idle,
  input  logic              conv_done,
  input  logic              start_conv,
  input  logic              frame_mode,
  input  logic              frame_trig,
  input  logic              frame_err,
  input  logic              fifo_push,
  input  logic              fifo_pop,
  output logic              dma_start,
  output logic [31:0]       dma_addr,
  output logic [LEN_W-1:0]  dma_len
);
  import dacseq_pkg::*;

  logic [31:0]      base_q;
  logic [LEN_W-1:0] len_q;
  logic             wr_base, wr_len;
  logic [CNT_W-1:0] conv_cnt;
  logic             conv_clr;
  logic [LVL_W-1:0] fill_lvl;

  assign wr_base = wr_en && (addr == ADDR_W'(OFS_BASE));
  assign wr_len  = wr_en && (addr == ADDR_W'(OFS_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (wr_base) base_q <= wdata;
      if (wr_len)  len_q  <= wdata[LEN_W-1:0];
    end
  end

  dacseq_dma_start #(.ADDR_W(32), .LEN_W(LEN_W)) u_start (
    .clk(clk), .rst_n(rst_n), .len_wr(wr_len), .idle(dma_idle),
    .base_q(base_q), .len_in(wdata[LEN_W-1:0]),
    .start(dma_start), .addr_lat(dma_addr), .len_lat(dma_len)
  );

  dacseq_conv_cnt #(.CNT_W(CNT_W)) u_conv (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .start_conv(start_conv),
    .frame_mode(frame_mode), .frame_trig(frame_trig), .frame_err(frame_err),
    .cnt(conv_cnt), .clr_evt(conv_clr)
  );

  dacseq_fill_level #(.LVL_W(LVL_W), .BYTES_PER_SAMPLE(BYTES_PER_SAMPLE)) u_fill (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .pop(fifo_pop), .level(fill_lvl)
  );

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_CONV))      rdata = 32'(conv_cnt);
    else if (addr == ADDR_W'(OFS_FILL)) rdata = 32'(fill_lvl);
    else if (addr == ADDR_W'(OFS_BASE)) rdata = base_q;
    else if (addr == ADDR_W'(OFS_LEN))  rdata = 32'(len_q);
  end

  assert_ro_conv_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_CONV) && !conv_done && !conv_clr) |=> $stable(conv_cnt));
endmodule

// File: tb/dacseq_dma_regs_test.sv
module dacseq_dma_regs_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic dma_idle = 0, conv_done = 0, start_conv = 0, frame_mode = 0;
  logic frame_trig = 0, frame_err = 0, fifo_push = 0, fifo_pop = 0;
  logic dma_start;
  logic [31:0] dma_addr;
  logic [27:0] dma_len;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dacseq_dma_regs uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic cyc(logic cd, logic sc, logic ft, logic fe, logic pu, logic po);
    @(negedge clk);
    conv_done = cd; start_conv = sc; frame_trig = ft; frame_err = fe;
    fifo_push = pu; fifo_pop = po;
    @(negedge clk);
    conv_done = 0; start_conv = 0; frame_trig = 0; frame_err = 0;
    fifo_push = 0; fifo_pop = 0;
  endtask

  task automatic t_reset;
    rd_chk("R1 conv", 4'h0, 0); rd_chk("R1 fill", 4'h4, 0);
    rd_chk("R1 base", 4'h8, 0); rd_chk("R1 len", 4'hC, 0);
    chk("R1 start", dma_start, 0); chk("R1 addr", dma_addr, 0); chk("R1 dlen", dma_len, 0);
  endtask

  task automatic t_regs;
    dma_idle = 0;
    wr(4'h8, 32'hDEADBEEF); rd_chk("R2 base rw", 4'h8, 32'hDEADBEEF);
    wr(4'hC, 32'hFFFFFFFF);
    chk("R5 no start busy", dma_start, 0);
    rd_chk("R3 len upper zero", 4'hC, 32'h0FFFFFFF);
    chk("R5 dlen unchanged", dma_len, 0);
    chk("R5 daddr unchanged", dma_addr, 0);
  endtask

  task automatic t_start;
    dma_idle = 1;
    wr(4'h8, 32'h12345678);
    wr(4'hC, 32'hF0000100);
    chk("R4 start pulse", dma_start, 1);
    chk("R4 addr", dma_addr, 32'h12345678);
    chk("R4 len", dma_len, 32'h100);
    @(negedge clk); chk("R4 single cycle", dma_start, 0);
    wr(4'h8, 32'hAAAA0000);
    chk("R6 addr held", dma_addr, 32'h12345678);
    rd_chk("R2 base new", 4'h8, 32'hAAAA0000);
    dma_idle = 0;
    wr(4'hC, 32'h40);
    chk("R5 busy no start", dma_start, 0);
    chk("R5 len held", dma_len, 32'h100);
    chk("R6 addr held busy", dma_addr, 32'h12345678);
    rd_chk("R3 len stored", 4'hC, 32'h40);
  endtask

  task automatic t_readonly;
    wr(4'h0, 32'h55); rd_chk("R13 conv ro", 4'h0, 0);
    wr(4'h4, 32'h77); rd_chk("R13 fill ro", 4'h4, 0);
  endtask

  task automatic t_normal;
    frame_mode = 0;
    for (int i = 0; i < 5; i++) cyc(1,0,0,0,0,0);
    rd_chk("R7 count 5", 4'h0, 5);
    cyc(0,0,1,0,0,0); rd_chk("R8 trig ignored", 4'h0, 5);
    cyc(0,1,0,0,0,0); rd_chk("R8 start clears", 4'h0, 0);
    for (int i = 0; i < 3; i++) cyc(1,0,0,0,0,0);
    rd_chk("R7 count 3", 4'h0, 3);
    cyc(1,1,0,0,0,0); rd_chk("R10 clear wins normal", 4'h0, 0);
  endtask

  task automatic t_frame;
    frame_mode = 1;
    for (int i = 0; i < 4; i++) cyc(1,0,0,0,0,0);
    cyc(0,1,0,0,0,0); rd_chk("R9 start ignored", 4'h0, 4);
    cyc(0,0,1,1,0,0); rd_chk("R9 frame err no clear", 4'h0, 4);
    cyc(0,0,1,0,0,0); rd_chk("R9 trig clears", 4'h0, 0);
    cyc(1,0,0,0,0,0); cyc(1,0,0,0,0,0);
    cyc(1,0,1,0,0,0); rd_chk("R10 clear wins frame", 4'h0, 0);
    frame_mode = 0;
  endtask

  task automatic t_fifo;
    for (int i = 0; i < 3; i++) cyc(0,0,0,0,1,0);
    rd_chk("R11 push", 4'h4, 6);
    cyc(0,0,0,0,1,1); rd_chk("R11 push+pop", 4'h4, 6);
    cyc(0,0,0,0,0,1); rd_chk("R11 pop", 4'h4, 4);
    cyc(0,0,0,0,0,1); cyc(0,0,0,0,0,1); rd_chk("R11 empty", 4'h4, 0);
    cyc(0,0,0,0,0,1); rd_chk("R12 floor", 4'h4, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_regs; t_readonly; t_start; t_normal; t_frame; t_fifo;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule